// File: doc/BRIEF.md
# Operation Unit with Condition-Flag Compares

This block performs the arithmetic, logic and shift step of a small 16-bit load/store core. It also produces the single condition bit that later conditional instructions test. It takes a 6-bit operation code and two register operands: a source and a destination. The top bit of the code splits the operation space in two:

- Codes with a clear top bit are data operations. They give a result for register write-back.
- Codes with a set top bit are compares. They give a new condition bit and no register result.

The result path is purely combinational. The condition bit is held in a register inside the block. That register is loaded at a clock edge whenever the cycle's flag write-enable is high. A separate clear request forces the bit to zero, and it does so regardless of the operation code in the same cycle.

Top module: `alu_cmpflag`

## Requirements
- R1: ADD (000000) gives src + dst, and SUB (000001) gives src − dst, both wrapping modulo 2^16.
- R2: AND (000010), OR (000011) and XOR (000100) give the bitwise combination of src and dst.
- R3: NOT (000101) gives the bitwise inverse of src; dst has no effect on the result.
- R4: SHL (000110), SHR (000111) and ASR (001000) shift src by exactly one bit. SHL and SHR fill the vacated bit with zero. ASR copies bit 15 into the vacated top bit.
- R5: Every defined data code asserts `res_we`. Without a clear request, it deasserts `flag_we` and leaves `flag_q` unchanged.
- R6: EQ (100000), NE (100001), GT (100010) and LT (100011) compare src with dst as unsigned values (GT: src > dst, LT: src < dst). Each asserts `flag_we`, deasserts `res_we` and drives `result` to zero.
- R7: EZ (100100) and NZ (100101) test only src against zero; dst has no effect on `flag_nxt`.
- R8: Any other code deasserts both `res_we` and `flag_we` and drives `result` to zero.
- R9: A high `flag_clr` asserts `flag_we` with `flag_nxt` = 0, overriding any compare outcome. It does not change `result` or `res_we`.
- R10: `flag_q` is 0 after reset. At each rising edge it takes `flag_nxt` when `flag_we` is high, and otherwise keeps its value.
- R11: While `flag_we` is low, `flag_nxt` equals `flag_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 6 | Operation code |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| flag_clr | input | 1 | Request to clear the condition bit |
| result | output | 16 | Data-operation result |
| res_we | output | 1 | Result is valid for write-back |
| flag_nxt | output | 1 | Condition value to be stored |
| flag_we | output | 1 | Condition register load enable |
| flag_q | output | 1 | Stored condition bit |

## Verification
On every cycle, the assertions check how the enables are separated by the code's top bit. They also check that the clear request overrides any compare, that the zero tests ignore dst, and that `flag_q` loads or holds exactly as `flag_we` says. The arithmetic itself is shown only by the bench's scenarios, which compare each output against a behavioural model. These scenarios cover wrap-around sums and differences, shift fill bits, unsigned compare edges at 0 and 0xFFFF, undefined codes, and clears that meet a compare.

// File: rtl/alu_cf_pkg.sv
package alu_cf_pkg;
   localparam int OP_W = 6;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 6'b000000,
      OP_SUB = 6'b000001,
      OP_AND = 6'b000010,
      OP_OR  = 6'b000011,
      OP_XOR = 6'b000100,
      OP_NOT = 6'b000101,
      OP_SHL = 6'b000110,
      OP_SHR = 6'b000111,
      OP_ASR = 6'b001000,
      OP_EQ  = 6'b100000,
      OP_NE  = 6'b100001,
      OP_GT  = 6'b100010,
      OP_LT  = 6'b100011,
      OP_EZ  = 6'b100100,
      OP_NZ  = 6'b100101
   } op_e;

   function automatic logic is_cmp_class(input logic [OP_W-1:0] code);
      return code[OP_W-1];
   endfunction
endpackage

// File: rtl/alu_cf_data.sv
module alu_cf_data
   import alu_cf_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   output logic [WIDTH-1:0] res,
   output logic             valid
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] sum_v, dif_v;
   logic [WIDTH-1:0] shl_v, shr_v, asr_v;

   assign sum_v = src + dst;
   assign dif_v = src - dst;
   assign shl_v = {src[MSB-1:0], 1'b0};
   assign shr_v = {1'b0, src[MSB:1]};
   assign asr_v = {src[MSB], src[MSB:1]};

   always_comb begin
      res   = '0;
      valid = 1'b1;
      case (op)
         OP_ADD:  res = sum_v;
         OP_SUB:  res = dif_v;
         OP_AND:  res = src & dst;
         OP_OR:   res = src | dst;
         OP_XOR:  res = src ^ dst;
         OP_NOT:  res = ~src;
         OP_SHL:  res = shl_v;
         OP_SHR:  res = shr_v;
         OP_ASR:  res = asr_v;
         default: valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_cf_cmp.sv
module alu_cf_cmp
   import alu_cf_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   output logic             hit,
   output logic             valid
);
   logic eq_v, gt_v, lt_v, zero_v;

   assign eq_v   = (src == dst);
   assign zero_v = (src == '0);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign gt_v = ($signed(src) > $signed(dst));
         assign lt_v = ($signed(src) < $signed(dst));
      end else begin : g_unsigned
         assign gt_v = (src > dst);
         assign lt_v = (src < dst);
      end
   endgenerate

   always_comb begin
      hit   = 1'b0;
      valid = 1'b1;
      case (op)
         OP_EQ:   hit = eq_v;
         OP_NE:   hit = ~eq_v;
         OP_GT:   hit = gt_v;
         OP_LT:   hit = lt_v;
         OP_EZ:   hit = zero_v;
         OP_NZ:   hit = ~zero_v;
         default: valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_cf_flag.sv
module alu_cf_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= d;
   end
endmodule

// File: rtl/alu_cmpflag.sv
module alu_cmpflag
   import alu_cf_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit SIGNED_CMP = 1'b0,
   parameter bit FLAG_RST   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [5:0]       op,
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   input  logic             flag_clr,
   output logic [WIDTH-1:0] result,
   output logic             res_we,
   output logic             flag_nxt,
   output logic             flag_we,
   output logic             flag_q
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_cmpflag: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] data_res;
   logic             data_ok, cmp_hit, cmp_ok;
   logic             is_cmp;

   assign is_cmp = is_cmp_class(op);

   alu_cf_data #(.WIDTH(WIDTH)) u_data (
      .op(op), .src(src), .dst(dst), .res(data_res), .valid(data_ok)
   );

   alu_cf_cmp #(.WIDTH(WIDTH), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .op(op), .src(src), .dst(dst), .hit(cmp_hit), .valid(cmp_ok)
   );

   always_comb begin
      res_we = data_ok & ~is_cmp;
      result = res_we ? data_res : '0;
      flag_we = flag_clr | (cmp_ok & is_cmp);
      if (flag_clr)                flag_nxt = 1'b0;
      else if (cmp_ok && is_cmp)   flag_nxt = cmp_hit;
      else                         flag_nxt = flag_q;
   end

   alu_cf_flag #(.RST_VAL(FLAG_RST)) u_flag (
      .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flag_nxt), .q(flag_q)
   );
endmodule

// File: rtl/alu_cmpflag_chk.sv
module alu_cmpflag_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [5:0]       op,
   input logic [WIDTH-1:0] src,
   input logic [WIDTH-1:0] dst,
   input logic             flag_clr,
   input logic [WIDTH-1:0] result,
   input logic             res_we,
   input logic             flag_nxt,
   input logic             flag_we,
   input logic             flag_q
);
   logic seen_edge;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_edge <= 1'b0;
      else        seen_edge <= 1'b1;
   end

   a_r5_data_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!op[5] && !flag_clr) |-> !flag_we);

   a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      op[5] |-> (!res_we && result == '0));

   a_r7_ez_src_only: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'b100100 && !flag_clr) |-> (flag_we && flag_nxt == (src == '0)));

   a_r8_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op > 6'b001000 && op < 6'b100000 && !flag_clr) |-> (!res_we && !flag_we));

   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |-> (flag_we && !flag_nxt));

   a_r10_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
      seen_edge |-> (flag_q == ($past(flag_we) ? $past(flag_nxt) : $past(flag_q))));

   a_r11_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |-> (flag_nxt == flag_q));
endmodule

bind alu_cmpflag alu_cmpflag_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .op(op), .src(src), .dst(dst),
   .flag_clr(flag_clr), .result(result), .res_we(res_we),
   .flag_nxt(flag_nxt), .flag_we(flag_we), .flag_q(flag_q)
);

// File: tb/tb_alu_cmpflag.sv
module tb_alu_cmpflag;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  op = '0;
   logic [15:0] src = '0, dst = '0;
   logic        flag_clr = 1'b0;
   logic [15:0] result;
   logic        res_we, flag_nxt, flag_we, flag_q;

   int n_vec = 0;
   int n_bad = 0;
   bit m_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_cmpflag dut (
      .clk(clk), .rst_n(rst_n), .op(op), .src(src), .dst(dst),
      .flag_clr(flag_clr), .result(result), .res_we(res_we),
      .flag_nxt(flag_nxt), .flag_we(flag_we), .flag_q(flag_q)
   );

   function automatic string tag_of(input logic [5:0] c, input bit clr);
      if (clr) return "R9";
      case (c)
         6'd0, 6'd1:                  return "R1";
         6'd2, 6'd3, 6'd4:            return "R2";
         6'd5:                        return "R3";
         6'd6, 6'd7, 6'd8:            return "R4";
         6'd32, 6'd33, 6'd34, 6'd35:  return "R6";
         6'd36, 6'd37:                return "R7";
         default:                     return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] c, input logic [15:0] s, input logic [15:0] d, input bit clr);
      int e_res, e_rwe, e_fwe, e_fn;
      string t;
      @(negedge clk);
      op = c; src = s; dst = d; flag_clr = clr;
      t = tag_of(c, clr);
      e_res = 0; e_rwe = 0; e_fwe = 0; e_fn = m_flag;
      case (c)
         6'd0: begin e_res = (s + d) % 65536; e_rwe = 1; end
         6'd1: begin e_res = (s - d + 65536) % 65536; e_rwe = 1; end
         6'd2: begin e_res = s & d; e_rwe = 1; end
         6'd3: begin e_res = s | d; e_rwe = 1; end
         6'd4: begin e_res = s ^ d; e_rwe = 1; end
         6'd5: begin e_res = 16'hFFFF - s; e_rwe = 1; end
         6'd6: begin e_res = (s * 2) % 65536; e_rwe = 1; end
         6'd7: begin e_res = s / 2; e_rwe = 1; end
         6'd8: begin e_res = s / 2 + (s >= 16'h8000 ? 16'h8000 : 0); e_rwe = 1; end
         6'd32: begin e_fwe = 1; e_fn = (s == d); end
         6'd33: begin e_fwe = 1; e_fn = (s != d); end
         6'd34: begin e_fwe = 1; e_fn = (int'(s) > int'(d)); end
         6'd35: begin e_fwe = 1; e_fn = (int'(s) < int'(d)); end
         6'd36: begin e_fwe = 1; e_fn = (s == 0); end
         6'd37: begin e_fwe = 1; e_fn = (s != 0); end
         default: ;
      endcase
      if (clr) begin e_fwe = 1; e_fn = 0; end
      #1;
      check(t, "result", int'(result), e_res);
      check(t, "res_we", int'(res_we), e_rwe);
      check(t, "flag_we", int'(flag_we), e_fwe);
      check(t, "flag_nxt", int'(flag_nxt), e_fn);
      if (e_fwe != 0) m_flag = bit'(e_fn);
      @(posedge clk); #1;
      check("R10", "flag_q", int'(flag_q), int'(m_flag));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (2) @(posedge clk);
      #1;
      check("R10", "reset flag_q", int'(flag_q), 0);
      rst_n = 1'b1;
      // R1 wrap corners
      apply(6'd0, 16'hFFFF, 16'h0001, 0);
      apply(6'd1, 16'h0000, 16'h0001, 0);
      apply(6'd1, 16'h1234, 16'h0234, 0);
      // R2 / R3 (dst must not matter for NOT)
      apply(6'd2, 16'hF0F0, 16'h3C3C, 0);
      apply(6'd3, 16'hF0F0, 16'h3C3C, 0);
      apply(6'd4, 16'hF0F0, 16'h3C3C, 0);
      apply(6'd5, 16'hA5A5, 16'h1234, 0);
      // R4 fill bits
      apply(6'd6, 16'h8001, 16'h0, 0);
      apply(6'd7, 16'h8001, 16'h0, 0);
      apply(6'd8, 16'h8001, 16'h0, 0);
      apply(6'd8, 16'h4002, 16'h0, 0);
      // R6 unsigned edges, R5 flag held across data op
      apply(6'd34, 16'hFFFF, 16'h0000, 0);
      apply(6'd0, 16'h1, 16'h1, 0);
      apply(6'd35, 16'hFFFF, 16'h0000, 0);
      apply(6'd32, 16'h7777, 16'h7777, 0);
      apply(6'd33, 16'h7777, 16'h7777, 0);
      // R7 dst ignored
      apply(6'd36, 16'h0000, 16'hFFFF, 0);
      apply(6'd37, 16'h0000, 16'hFFFF, 0);
      apply(6'd37, 16'h0100, 16'h0000, 0);
      // R8 undefined codes, R11 hold
      apply(6'd9, 16'h1111, 16'h2222, 0);
      apply(6'd31, 16'h1111, 16'h2222, 0);
      apply(6'd63, 16'h1111, 16'h2222, 0);
      // R9 clear beats compare, leaves data result
      apply(6'd32, 16'h5, 16'h5, 1);
      apply(6'd37, 16'h5, 16'h0, 0);
      apply(6'd0, 16'h3, 16'h4, 1);
      for (int i = 0; i < 400; i++) begin
         logic [5:0] c;
         c = 6'($urandom_range(0, 63));
         if ((i % 3) == 0) c = 6'($urandom_range(32, 37));
         else if ((i % 3) == 1) c = 6'($urandom_range(0, 8));
         apply(c, 16'($urandom), ((i % 7) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom),
               (i % 11) == 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule